// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 32-bit effective address into a physical address by searching a hashed page table in memory. A lookup request carries the effective address. Its top nibble picks one of sixteen internal segment registers, and that register supplies a 24-bit virtual segment ID. The walker hashes the segment ID with the page index. It then forms two 64-byte group addresses, a primary one and a secondary one, from a table base and mask setting. It reads the entries of these groups over a memory read port that allows only one read in flight at a time.

Each group holds eight entries of two 32-bit words. The walker reads the first word of each entry in turn and reads the second word only when the first word matches. The lookup ends with a hit, which returns the real page joined to the 4 KB page offset, or with a miss. The table base and mask may change only while no walk is running. The segment registers can be written only while the walker is idle.

Top module: `hpt_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0.
- R2: Bits [31:28] of the effective address select segment register 0 to 15, which is written through seg_we/seg_idx/seg_vsid. The 24-bit value read supplies the segment ID for the lookup.
- R3: The primary hash is the 19-bit value `vsid[18:0] ^ {3'b0, ea[27:12]}`. A group address is `{cfg_org,16'h0} | ((hash[18:10] & cfg_mask) << 16) | (hash[9:0] << 6)`.
- R4: Entry i of a group is read at group+8*i for word 0 and at group+8*i+4 for word 1. Entries are read from index 0 upward. Word 1 is read only after word 0 matches, and the walk stops at the first match.
- R5: Word 0 of an entry holds valid in bit 31, the segment ID in bits [30:7], the hash-select flag in bit 6 and the abbreviated page index in bits [5:0]. In the primary group an entry matches when valid is 1, the segment ID equals the selected one, bits [5:0] equal ea[27:22], and the flag is 0.
- R6: When no primary entry matches, the secondary group is searched. It is formed from the bitwise complement of the primary hash, and its entries match only when the flag is 1.
- R7: On a match, rsp_hit is 1 and rsp_pa is {word1[31:12], ea[11:0]}.
- R8: When none of the 16 entries match, rsp_hit is 0 after exactly 16 word-0 reads.
- R9: A response stays valid and unchanged until rsp_ready is 1. While the walker is not idle, req_ready is 0.
- R10: A write of cfg_org/cfg_mask made while the walker is busy does not affect that walk. The write takes effect once the walker returns to idle, before the next lookup.
- R11: A segment register write made while the walker is busy is discarded.
- R12: At most one memory read is in flight: after a read is accepted, mem_req_valid stays 0 until mem_rvalid returns data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Walker can accept a lookup |
| req_ea | input | 32 | Effective address to translate |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result accepted |
| rsp_hit | output | 1 | 1 = translation found, 0 = miss |
| rsp_pa | output | 32 | Physical address on a hit |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_addr | output | 32 | Byte address of the word to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| cfg_we | input | 1 | Table base/mask write strobe |
| cfg_org | input | 16 | Table base, bits [31:16] of the table address |
| cfg_mask | input | 9 | Mask on the upper hash bits |
| seg_we | input | 1 | Segment register write strobe |
| seg_idx | input | 4 | Segment register index |
| seg_vsid | input | 24 | Segment ID to write |

## Verification
The bench places entries in the primary group that must be skipped: the flag is wrong or the valid bit is clear, yet the rest of the entry matches. A walker that ignores either field reports a hit from the wrong place. It also checks that the secondary search starts at the complemented-hash address, and that a miss costs exactly sixteen first-word reads. A second-word read on a near match, or a stray read, changes that count.

Two lookups use the same page and differ only in the segment nibble. A walker that picks the wrong segment register forms the wrong group address. Base/mask writes and segment writes are issued in the middle of a walk. A walker that applies them at once either corrupts the walk in progress or loses the segment write protection.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ0,
    S_WAIT0,
    S_REQ1,
    S_WAIT1,
    S_RESP
  } walk_state_t;
endpackage

// File: rtl/hpt_segfile.sv
module hpt_segfile #(
  parameter int N  = 16,
  parameter int IW = 4,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (we) regs[widx] <= wdata;
  end

  assign rdata = regs[ridx];
endmodule

// File: rtl/hpt_grpaddr.sv
module hpt_grpaddr #(
  parameter int AW     = 32,
  parameter int PIDX_W = 16,
  parameter int HASH_W = 19,
  parameter int HLO_W  = 10,
  parameter int GRP_SH = 6,
  localparam int ORG_LSB = HLO_W + GRP_SH,
  localparam int ORG_W   = AW - ORG_LSB,
  localparam int MASK_W  = HASH_W - HLO_W
) (
  input  logic [HASH_W-1:0] vsid_lo,
  input  logic [PIDX_W-1:0] pidx,
  input  logic [ORG_W-1:0]  org,
  input  logic [MASK_W-1:0] mask,
  input  logic              sec,
  output logic [AW-1:0]     grp
);
  logic [HASH_W-1:0] h;

  always_comb begin
    h = vsid_lo ^ HASH_W'(pidx);
    if (sec) h = ~h;
    grp = {org, {ORG_LSB{1'b0}}}
        | (AW'(h[HASH_W-1:HLO_W] & mask) << ORG_LSB)
        | (AW'(h[HLO_W-1:0]) << GRP_SH);
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker #(
  parameter int AW      = 32,
  parameter int SEG_N   = 16,
  parameter int VSID_W  = 24,
  parameter int PIDX_W  = 16,
  parameter int OFF_W   = 12,
  parameter int API_W   = 6,
  parameter int HASH_W  = 19,
  parameter int HLO_W   = 10,
  parameter int GRP_ENT = 8,
  localparam int SEL_W   = $clog2(SEG_N),
  localparam int IDX_W   = $clog2(GRP_ENT),
  localparam int GRP_SH  = IDX_W + 3,
  localparam int ORG_LSB = HLO_W + GRP_SH,
  localparam int ORG_W   = AW - ORG_LSB,
  localparam int MASK_W  = HASH_W - HLO_W,
  localparam int RPN_W   = AW - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_ea,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [AW-1:0]     rsp_pa,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rvalid,
  input  logic [AW-1:0]     mem_rdata,
  input  logic              cfg_we,
  input  logic [ORG_W-1:0]  cfg_org,
  input  logic [MASK_W-1:0] cfg_mask,
  input  logic              seg_we,
  input  logic [SEL_W-1:0]  seg_idx,
  input  logic [VSID_W-1:0] seg_vsid
);
  import hpt_pkg::*;

  walk_state_t       state;
  logic [AW-1:0]     ea_q;
  logic [VSID_W-1:0] vsid_q;
  logic              sec_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ORG_W-1:0]  org_q, pend_org_q;
  logic [MASK_W-1:0] mask_q, pend_mask_q;
  logic              pend_q;
  logic              idle;
  logic [VSID_W-1:0] seg_rd;
  logic [AW-1:0]     grp;
  logic              w0_match;

  assign idle = (state == S_IDLE);

  hpt_segfile #(.N(SEG_N), .IW(SEL_W), .DW(VSID_W)) u_seg (
    .clk   (clk),
    .we    (seg_we && idle),
    .widx  (seg_idx),
    .wdata (seg_vsid),
    .ridx  (req_ea[AW-1 -: SEL_W]),
    .rdata (seg_rd)
  );

  hpt_grpaddr #(.AW(AW), .PIDX_W(PIDX_W), .HASH_W(HASH_W), .HLO_W(HLO_W),
                .GRP_SH(GRP_SH)) u_hash (
    .vsid_lo (vsid_q[HASH_W-1:0]),
    .pidx    (ea_q[OFF_W +: PIDX_W]),
    .org     (org_q),
    .mask    (mask_q),
    .sec     (sec_q),
    .grp     (grp)
  );

  // First-word compare: valid, segment ID, hash-select, abbreviated index
  assign w0_match = mem_rdata[AW-1]
                 && (mem_rdata[AW-2 -: VSID_W] == vsid_q)
                 && (mem_rdata[API_W] == sec_q)
                 && (mem_rdata[API_W-1:0] == ea_q[AW-SEL_W-1 -: API_W]);

  assign req_ready     = idle && !pend_q;
  assign rsp_valid     = (state == S_RESP);
  assign mem_req_valid = (state == S_REQ0) || (state == S_REQ1);
  assign mem_addr      = grp | AW'({idx_q, (state == S_REQ1), 2'b00});

  // Table base/mask register with hold-off while a walk runs
  always_ff @(posedge clk) begin
    if (rst) begin
      org_q       <= '0;
      mask_q      <= '0;
      pend_q      <= 1'b0;
      pend_org_q  <= '0;
      pend_mask_q <= '0;
    end else if (cfg_we) begin
      if (idle) begin
        org_q  <= cfg_org;
        mask_q <= cfg_mask;
        pend_q <= 1'b0;
      end else begin
        pend_q      <= 1'b1;
        pend_org_q  <= cfg_org;
        pend_mask_q <= cfg_mask;
      end
    end else if (pend_q && idle) begin
      org_q  <= pend_org_q;
      mask_q <= pend_mask_q;
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      ea_q    <= '0;
      vsid_q  <= '0;
      sec_q   <= 1'b0;
      idx_q   <= '0;
      rsp_hit <= 1'b0;
      rsp_pa  <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid && req_ready) begin
          ea_q   <= req_ea;
          vsid_q <= seg_rd;
          sec_q  <= 1'b0;
          idx_q  <= '0;
          state  <= S_REQ0;
        end
        S_REQ0: if (mem_req_ready) state <= S_WAIT0;
        S_WAIT0: if (mem_rvalid) begin
          if (w0_match) begin
            state <= S_REQ1;
          end else if (idx_q == IDX_W'(GRP_ENT - 1)) begin
            if (sec_q) begin
              rsp_hit <= 1'b0;
              rsp_pa  <= '0;
              state   <= S_RESP;
            end else begin
              sec_q <= 1'b1;
              idx_q <= '0;
              state <= S_REQ0;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
            state <= S_REQ0;
          end
        end
        S_REQ1: if (mem_req_ready) state <= S_WAIT1;
        S_WAIT1: if (mem_rvalid) begin
          rsp_hit <= 1'b1;
          rsp_pa  <= {mem_rdata[AW-1 -: RPN_W], ea_q[OFF_W-1:0]};
          state   <= S_RESP;
        end
        S_RESP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_pa)); // R9
  AST_PA_OFFSET: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_hit |-> rsp_pa[OFF_W-1:0] == ea_q[OFF_W-1:0]); // R7
  AST_ONE_READ: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_ready |=> !mem_req_valid); // R12
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    $past(state) != S_IDLE |-> $stable(org_q) && $stable(mask_q)); // R10
endmodule

// File: tb/hpt_walker_bench.sv
module hpt_walker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1;
  logic        req_valid = 0, rsp_ready = 0, mem_req_ready = 1;
  logic        mem_rvalid = 0, cfg_we = 0, seg_we = 0;
  logic [31:0] req_ea = 0, mem_rdata = 0;
  logic [15:0] cfg_org = 0;
  logic [8:0]  cfg_mask = 0;
  logic [3:0]  seg_idx = 0;
  logic [23:0] seg_vsid = 0;
  logic        req_ready, rsp_valid, rsp_hit, mem_req_valid;
  logic [31:0] rsp_pa, mem_addr;

  int tests = 0, fails = 0;
  logic [31:0] mem_m [logic [31:0]];
  logic [31:0] rlog [64];
  int nreads = 0, cnt = 0, overlap_err = 0;
  logic [31:0] addr_pend;
  logic [23:0] segv [16];
  logic [15:0] cur_org;
  logic [8:0]  cur_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpt_walker u_hpt_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_ea(req_ea), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_pa(rsp_pa), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .cfg_we(cfg_we), .cfg_org(cfg_org), .cfg_mask(cfg_mask),
    .seg_we(seg_we), .seg_idx(seg_idx), .seg_vsid(seg_vsid)
  );

  // Memory model: fixed two-cycle read latency, logs every request
  always @(negedge clk) begin
    if (rst) begin
      cnt = 0;
      mem_rvalid = 0;
    end else begin
      mem_rvalid = 0;
      if (cnt != 0) begin
        cnt--;
        if (cnt == 0) begin
          mem_rvalid = 1;
          mem_rdata  = mem_m.exists(addr_pend) ? mem_m[addr_pend] : 32'h0;
        end
      end
      if (mem_req_valid) begin
        if (cnt != 0 || mem_rvalid) overlap_err++;
        addr_pend = mem_addr;
        cnt = 2;
        if (nreads < 64) rlog[nreads] = mem_addr;
        nreads++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] grp_of(input logic [23:0] v, input logic [31:0] ea,
                                         input bit sec, input logic [15:0] org,
                                         input logic [8:0] msk);
    logic [18:0] h;
    h = v[18:0] ^ {3'b0, ea[27:12]};
    if (sec) h = ~h;
    return {org, 16'h0} | ({23'h0, h[18:10] & msk} << 16) | ({22'h0, h[9:0]} << 6);
  endfunction

  function automatic logic [31:0] w0_of(input bit v, input logic [23:0] vs,
                                        input bit h, input logic [31:0] ea);
    return {v, vs, h, ea[27:22]};
  endfunction

  task automatic put(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1);
    mem_m[a] = w0;
    mem_m[a + 4] = w1;
  endtask

  task automatic write_seg(input logic [3:0] i, input logic [23:0] v);
    @(negedge clk); seg_we = 1; seg_idx = i; seg_vsid = v;
    @(negedge clk); seg_we = 0;
  endtask

  task automatic write_cfg(input logic [15:0] o, input logic [8:0] m);
    @(negedge clk); cfg_we = 1; cfg_org = o; cfg_mask = m;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic start_req(input logic [31:0] ea);
    @(negedge clk);
    nreads = 0;
    req_valid = 1; req_ea = ea;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_rsp(output logic hit, output logic [31:0] pa);
    while (!rsp_valid) @(negedge clk);
    hit = rsp_hit; pa = rsp_pa;
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic t_reset;
    chk(req_ready == 1, "R1", "req_ready after reset", 32'(req_ready), 1);
    chk(rsp_valid == 0, "R1", "rsp_valid after reset", 32'(rsp_valid), 0);
    chk(mem_req_valid == 0, "R1", "mem_req_valid after reset", 32'(mem_req_valid), 0);
  endtask

  task automatic t_primary_hit;
    logic h; logic [31:0] pa, pg, ea;
    ea = 32'h3456_7ABC;
    mem_m.delete();
    pg = grp_of(segv[3], ea, 0, cur_org, cur_mask);
    put(pg + 8*1, w0_of(1, segv[3], 0, ea) ^ 32'h1, 32'hDEAD_0000);
    put(pg + 8*3, w0_of(1, segv[3], 0, ea), 32'hABCD_E000);
    start_req(ea); wait_rsp(h, pa);
    chk(rlog[0] == pg, "R3", "primary group address", rlog[0], pg);
    chk(h == 1, "R5", "primary hit flag", 32'(h), 1);
    chk(pa == 32'hABCD_EABC, "R7", "primary hit pa", pa, 32'hABCD_EABC);
    chk(nreads == 5, "R4", "reads for hit at entry 3", nreads, 5);
    chk(rlog[3] == pg + 24 && rlog[4] == pg + 28, "R4", "entry 3 word addresses",
        rlog[4], pg + 28);
  endtask

  task automatic t_secondary_hit;
    logic h; logic [31:0] pa, pg, sg, ea;
    ea = 32'h7001_2345;
    mem_m.delete();
    pg = grp_of(segv[7], ea, 0, cur_org, cur_mask);
    sg = grp_of(segv[7], ea, 1, cur_org, cur_mask);
    put(pg, w0_of(1, segv[7], 1, ea), 32'h1111_1000);
    put(sg + 8*2, w0_of(1, segv[7], 1, ea), 32'h0246_8000);
    start_req(ea); wait_rsp(h, pa);
    chk(h == 1 && pa == 32'h0246_8345, "R6", "secondary hit pa", pa, 32'h0246_8345);
    chk(rlog[8] == sg, "R6", "secondary group address", rlog[8], sg);
    chk(nreads == 12, "R4", "reads for secondary entry 2", nreads, 12);
  endtask

  task automatic t_miss;
    logic h; logic [31:0] pa, pg, sg, ea;
    ea = 32'hC0FF_E123;
    mem_m.delete();
    pg = grp_of(segv[12], ea, 0, cur_org, cur_mask);
    sg = grp_of(segv[12], ea, 1, cur_org, cur_mask);
    put(pg + 8*5, w0_of(0, segv[12], 0, ea), 32'h5555_5000);
    put(sg + 8*1, w0_of(1, segv[12], 0, ea), 32'h6666_6000);
    start_req(ea); wait_rsp(h, pa);
    chk(h == 0, "R8", "miss flag", 32'(h), 0);
    chk(nreads == 16, "R8", "reads on miss", nreads, 16);
  endtask

  task automatic t_seg_select;
    logic h; logic [31:0] pa, g1, g2;
    mem_m.delete();
    g1 = grp_of(segv[1], 32'h1222_2333, 0, cur_org, cur_mask);
    g2 = grp_of(segv[2], 32'h2222_2333, 0, cur_org, cur_mask);
    put(g1, w0_of(1, segv[1], 0, 32'h1222_2333), 32'h7777_7000);
    start_req(32'h1222_2333); wait_rsp(h, pa);
    chk(h == 1 && pa == 32'h7777_7333, "R2", "segment 1 hit", pa, 32'h7777_7333);
    start_req(32'h2222_2333); wait_rsp(h, pa);
    chk(rlog[0] == g2, "R2", "segment 2 group address", rlog[0], g2);
    chk(h == 0, "R2", "segment 2 miss", 32'(h), 0);
  endtask

  task automatic t_hold;
    logic h; logic [31:0] pa, pg, ea;
    ea = 32'h3456_7ABC;
    mem_m.delete();
    pg = grp_of(segv[3], ea, 0, cur_org, cur_mask);
    put(pg, w0_of(1, segv[3], 0, ea), 32'h0BAD_F000);
    start_req(ea);
    while (!rsp_valid) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(rsp_valid == 1 && rsp_pa == 32'h0BAD_FABC, "R9", "response held", rsp_pa,
        32'h0BAD_FABC);
    chk(req_ready == 0, "R9", "req_ready while busy", 32'(req_ready), 0);
    wait_rsp(h, pa);
    @(negedge clk);
    chk(rsp_valid == 0 && req_ready == 1, "R9", "idle after accept", 32'(rsp_valid), 0);
  endtask

  task automatic t_cfg_deferred;
    logic h; logic [31:0] pa, pg, ea, ng;
    ea = 32'h3456_7ABC;
    mem_m.delete();
    pg = grp_of(segv[3], ea, 0, cur_org, cur_mask);
    put(pg + 8*6, w0_of(1, segv[3], 0, ea), 32'h4242_4000);
    start_req(ea);
    write_cfg(16'h0020, 9'h000);
    wait_rsp(h, pa);
    chk(h == 1 && pa == 32'h4242_4ABC, "R10", "walk keeps old table", pa, 32'h4242_4ABC);
    cur_org = 16'h0020; cur_mask = 9'h000;
    ng = grp_of(segv[3], ea, 0, cur_org, cur_mask);
    start_req(ea); wait_rsp(h, pa);
    chk(rlog[0] == ng, "R10", "next walk uses new table", rlog[0], ng);
  endtask

  task automatic t_seg_blocked;
    logic h; logic [31:0] pa, pg, ea;
    ea = 32'h5123_4567;
    mem_m.delete();
    pg = grp_of(segv[5], ea, 0, cur_org, cur_mask);
    put(pg, w0_of(1, segv[5], 0, ea), 32'h9999_9000);
    start_req(ea);
    write_seg(5, 24'hFEDCBA);
    wait_rsp(h, pa);
    start_req(ea); wait_rsp(h, pa);
    chk(h == 1 && pa == 32'h9999_9567, "R11", "segment write during walk dropped", pa,
        32'h9999_9567);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    for (int i = 0; i < 16; i++) begin
      segv[i] = 24'h012300 + 24'(i) * 24'h010111;
      write_seg(4'(i), segv[i]);
    end
    cur_org = 16'h0010; cur_mask = 9'h003;
    write_cfg(cur_org, cur_mask);
    t_primary_hit();
    t_secondary_hit();
    t_miss();
    t_seg_select();
    t_hold();
    t_seg_blocked();
    t_cfg_deferred();
    chk(overlap_err == 0, "R12", "overlapping memory reads", overlap_err, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule